// File: doc/BRIEF.md
# Three-Phase Pattern Buffer Transfer Controller

This block decides when a pair of software-written pattern buffers is copied into the working output pattern of a three-phase inverter driver, and when the dead-time counter next door is restarted. Software writes a low half and a high half of the next pattern into two buffer registers. A transfer trigger then copies both halves into the working pattern as one word. The trigger comes from the carrier timer running out, from software writing 1 to a trigger bit, or from a write to the carrier period register when that source is turned on.

What a trigger does depends on the modulation mode. In triangular mode a trigger only copies the buffers once after a fresh pair of writes, so a half-updated pattern never reaches the outputs. In sawtooth mode every trigger copies the buffers and also restarts the dead-time counter. In both modes a falling edge on any of the three phase one-shot pulses restarts the dead-time counter.

Buffer fill is tracked by a four-state machine. The states are ST_EMPTY (neither half written since the last copy), ST_HALF_A (low half only), ST_HALF_B (high half only) and ST_FRESH (both halves written). A write to the low half moves ST_EMPTY to ST_HALF_A and ST_HALF_B to ST_FRESH. A write to the high half moves ST_EMPTY to ST_HALF_B and ST_HALF_A to ST_FRESH. Writing both halves in one cycle moves ST_EMPTY to ST_FRESH. A copy returns the machine to ST_EMPTY, and any write in that same cycle is then applied on top of ST_EMPTY.

Top module: `phase_xfer_ctrl`

## Requirements
- R1: After a synchronous reset, `xfer_pulse` and `dt_trig` are 0, `pattern_out` is 0, both buffers hold 0 and the fill state is ST_EMPTY.
- R2: The trigger is asserted in a cycle when `carrier_uf` is 1, or when `sw_trig_wr` and `sw_trig_val` are both 1, or when `per_wr` and `per_src_en` are both 1. A software write of 0, or a period write with `per_src_en` at 0, is not a trigger.
- R3: When `saw_mode` is 0, a trigger copies the buffers only if the fill state is ST_FRESH. This is exactly one copy per fresh pair of buffer writes.
- R4: A trigger uses the fill state from before any buffer write in the same cycle. A buffer write in the cycle of a copy counts toward the next copy.
- R5: When `saw_mode` is 1, every trigger copies the buffers, whatever the fill state.
- R6: A copy loads `pattern_out` with {high buffer, low buffer} as they were before that edge. Between copies, `pattern_out` does not change.
- R7: When `saw_mode` is 0, `dt_trig` pulses only for a 1-to-0 change on some bit of `oneshot_in`, judged against its value in the previous cycle.
- R8: When `saw_mode` is 1, `dt_trig` also pulses for any trigger as defined in R2.
- R9: `xfer_pulse` and `dt_trig` are registered. Each is high for the one cycle after the edge at which its cause was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| carrier_uf | input | 1 | Carrier timer underflow pulse |
| sw_trig_wr | input | 1 | Software write strobe for the trigger bit |
| sw_trig_val | input | 1 | Value written to the trigger bit |
| per_wr | input | 1 | Carrier period register write strobe |
| per_src_en | input | 1 | Makes a period write a trigger source |
| oneshot_in | input | 3 | One-shot pulse levels for the three phases |
| saw_mode | input | 1 | 0 triangular, 1 sawtooth |
| buf_lo_wr | input | 1 | Write strobe for the low pattern buffer |
| buf_lo_data | input | PAT_W | Low buffer write data |
| buf_hi_wr | input | 1 | Write strobe for the high pattern buffer |
| buf_hi_data | input | PAT_W | High buffer write data |
| xfer_pulse | output | 1 | One-cycle copy strobe |
| pattern_out | output | 2*PAT_W | Working pattern, {high, low} |
| dt_trig | output | 1 | One-cycle dead-time counter restart |

## Verification
The bench goes after a trigger that lands in the same cycle as the second buffer write. A design that read the updated fill state there would copy a pattern that is half new in triangular mode. It also writes a buffer in the cycle of a copy. A design that cleared that write would drop the following copy. It checks that a software write of 0 and a period write with the source turned off cause no copy and no dead-time restart, which catches a design that decodes strobes alone. It also checks that one-shot rising edges never restart the dead-time counter in either mode, which catches edge detection with the wrong polarity.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_HALF_A = 2'd1,
        ST_HALF_B = 2'd2,
        ST_FRESH  = 2'd3
    } fill_e;
endpackage

// File: rtl/osh_fall.sv
module osh_fall #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic [N-1:0] fall
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) prev_q[i] <= 1'b0;
            else     prev_q[i] <= level[i];
        end
        assign fall[i] = prev_q[i] & ~level[i];
    end
endmodule

// File: rtl/trig_merge.sv
module trig_merge (
    input  logic carrier_uf,
    input  logic sw_trig_wr,
    input  logic sw_trig_val,
    input  logic per_wr,
    input  logic per_src_en,
    output logic trig
);
    always_comb begin
        trig = carrier_uf
             | (sw_trig_wr & sw_trig_val)
             | (per_wr & per_src_en);
    end
endmodule

// File: rtl/fill_fsm.sv
module fill_fsm
    import xfer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_a,
    input  logic  wr_b,
    input  logic  consume,
    output fill_e state
);
    fill_e base, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_EMPTY;
        else     state <= nxt;
    end

    always_comb begin
        base = consume ? ST_EMPTY : state;
        nxt  = base;
        unique case (base)
            ST_EMPTY: begin
                if (wr_a && wr_b) nxt = ST_FRESH;
                else if (wr_a)    nxt = ST_HALF_A;
                else if (wr_b)    nxt = ST_HALF_B;
            end
            ST_HALF_A: if (wr_b) nxt = ST_FRESH;
            ST_HALF_B: if (wr_a) nxt = ST_FRESH;
            ST_FRESH:  nxt = ST_FRESH;
        endcase
    end
endmodule

// File: rtl/phase_xfer_ctrl.sv
module phase_xfer_ctrl
    import xfer_pkg::*;
#(
    parameter int PAT_W = 6,
    parameter int NPH   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               carrier_uf,
    input  logic               sw_trig_wr,
    input  logic               sw_trig_val,
    input  logic               per_wr,
    input  logic               per_src_en,
    input  logic [NPH-1:0]     oneshot_in,
    input  logic               saw_mode,
    input  logic               buf_lo_wr,
    input  logic [PAT_W-1:0]   buf_lo_data,
    input  logic               buf_hi_wr,
    input  logic [PAT_W-1:0]   buf_hi_data,
    output logic               xfer_pulse,
    output logic [2*PAT_W-1:0] pattern_out,
    output logic               dt_trig
);
    localparam int OUT_W = 2 * PAT_W;

    logic             trig_any;
    logic [NPH-1:0]   fall_vec;
    logic             do_copy;
    logic             do_dt;
    fill_e            fill_q;
    logic [PAT_W-1:0] lo_q, hi_q;

    trig_merge u_trig (
        .carrier_uf (carrier_uf),
        .sw_trig_wr (sw_trig_wr),
        .sw_trig_val(sw_trig_val),
        .per_wr     (per_wr),
        .per_src_en (per_src_en),
        .trig       (trig_any)
    );

    osh_fall #(.N(NPH)) u_fall (
        .clk  (clk),
        .rst  (rst),
        .level(oneshot_in),
        .fall (fall_vec)
    );

    fill_fsm u_fill (
        .clk    (clk),
        .rst    (rst),
        .wr_a   (buf_lo_wr),
        .wr_b   (buf_hi_wr),
        .consume(do_copy),
        .state  (fill_q)
    );

    // Copy and dead-time decisions from the pre-edge fill state
    always_comb begin
        do_copy = trig_any && (saw_mode || (fill_q == ST_FRESH));
        do_dt   = (|fall_vec) || (saw_mode && trig_any);
    end

    // Buffer registers
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (buf_lo_wr) lo_q <= buf_lo_data;
            if (buf_hi_wr) hi_q <= buf_hi_data;
        end
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            xfer_pulse  <= 1'b0;
            dt_trig     <= 1'b0;
            pattern_out <= '0;
        end else begin
            xfer_pulse <= do_copy;
            dt_trig    <= do_dt;
            if (do_copy) pattern_out <= OUT_W'({hi_q, lo_q});
        end
    end
endmodule

// File: rtl/xfer_ctrl_chk.sv
module xfer_ctrl_chk
    import xfer_pkg::*;
#(
    parameter int PAT_W = 6,
    parameter int NPH   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               saw_mode,
    input logic               trig_any,
    input fill_e              fill_q,
    input logic [NPH-1:0]     fall_vec,
    input logic               xfer_pulse,
    input logic               dt_trig,
    input logic [2*PAT_W-1:0] pattern_out
);
    logic up;
    always_ff @(posedge clk) up <= !rst;

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!xfer_pulse && !dt_trig && pattern_out == '0));

    // R2
    a_r2_copy_needs_trig: assert property (@(posedge clk) disable iff (rst)
        (up && xfer_pulse) |-> $past(trig_any));

    // R3 R4
    a_r3_tri_needs_fresh: assert property (@(posedge clk) disable iff (rst)
        (up && xfer_pulse && !$past(saw_mode)) |-> $past(fill_q) == ST_FRESH);

    // R5
    a_r5_saw_every_trig: assert property (@(posedge clk) disable iff (rst)
        (up && $past(saw_mode) && $past(trig_any)) |-> xfer_pulse);

    // R6
    a_r6_hold_pattern: assert property (@(posedge clk) disable iff (rst)
        (up && !xfer_pulse) |-> $stable(pattern_out));

    // R7
    a_r7_tri_dt_from_fall: assert property (@(posedge clk) disable iff (rst)
        (up && dt_trig && !$past(saw_mode)) |-> ($past(fall_vec) != '0));

    // R8
    a_r8_saw_dt_on_trig: assert property (@(posedge clk) disable iff (rst)
        (up && $past(saw_mode) && $past(trig_any)) |-> dt_trig);
endmodule

bind phase_xfer_ctrl xfer_ctrl_chk #(.PAT_W(PAT_W), .NPH(NPH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .saw_mode   (saw_mode),
    .trig_any   (trig_any),
    .fill_q     (fill_q),
    .fall_vec   (fall_vec),
    .xfer_pulse (xfer_pulse),
    .dt_trig    (dt_trig),
    .pattern_out(pattern_out)
);

// File: tb/sim_phase_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_phase_xfer_ctrl;
    localparam int PW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic uf = 0, swwr = 0, swval = 0, perwr = 0, peren = 0, saw = 0;
    logic [2:0] os = '0;
    logic lowr = 0, hiwr = 0;
    logic [PW-1:0] lod = '0, hid = '0;
    logic xfer, dt;
    logic [2*PW-1:0] pat;

    int checks = 0, fails = 0;
    bit done = 0;

    // Model state
    bit m_a, m_b;
    logic [2:0] m_prev;
    logic [PW-1:0] m_lo, m_hi;
    logic [2*PW-1:0] m_pat;

    always #5 clk = ~clk;

    phase_xfer_ctrl #(.PAT_W(PW), .NPH(3)) u0 (
        .clk(clk), .rst(rst), .carrier_uf(uf), .sw_trig_wr(swwr),
        .sw_trig_val(swval), .per_wr(perwr), .per_src_en(peren),
        .oneshot_in(os), .saw_mode(saw), .buf_lo_wr(lowr),
        .buf_lo_data(lod), .buf_hi_wr(hiwr), .buf_hi_data(hid),
        .xfer_pulse(xfer), .pattern_out(pat), .dt_trig(dt)
    );

    function automatic bit f_trig(bit u, bit sw, bit sv, bit pw, bit pe);
        return u | (sw & sv) | (pw & pe);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_a = 0; m_b = 0; m_prev = '0; m_lo = '0; m_hi = '0; m_pat = '0;
    endtask

    // One clock with the current inputs; checks outputs after the edge
    task automatic step(string xtag, string dtag);
        bit t, xf, d;
        t  = f_trig(uf, swwr, swval, perwr, peren);
        xf = t && (saw || (m_a && m_b));
        d  = (|(m_prev & ~os)) || (saw && t);
        if (xf) m_pat = {m_hi, m_lo};
        @(posedge clk);
        #1;
        chk(xtag, 32'(xfer), 32'(xf));
        chk(dtag, 32'(dt), 32'(d));
        chk("R6 pattern", 32'(pat), 32'(m_pat));
        if (xf) begin m_a = 0; m_b = 0; end
        if (lowr) begin m_a = 1; m_lo = lod; end
        if (hiwr) begin m_b = 1; m_hi = hid; end
        m_prev = os;
    endtask

    task automatic idle_in();
        uf = 0; swwr = 0; swval = 0; perwr = 0; lowr = 0; hiwr = 0;
    endtask

    initial begin
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 xfer", 32'(xfer), 0);
        chk("R1 dt", 32'(dt), 0);
        chk("R1 pattern", 32'(pat), 0);

        // R2: software write of 0 and disabled period write are no trigger
        saw = 1; swwr = 1; swval = 0; perwr = 1; peren = 0;
        step("R2 sw0/per off xfer", "R2 sw0/per off dt");
        idle_in();
        // R2: enabled period write is a trigger
        perwr = 1; peren = 1;
        step("R2 per on xfer", "R2 per on dt");
        idle_in(); peren = 0;

        // R4: trigger with second write in same cycle uses old state (triangular)
        saw = 0; lowr = 1; lod = 6'h15;
        step("R3 write lo", "R7 write lo");
        idle_in(); hiwr = 1; hid = 6'h2a; uf = 1;
        step("R4 same-cycle no copy", "R7 quiet");
        idle_in(); uf = 1; lowr = 1; lod = 6'h07;
        step("R4 copy with write", "R7 quiet");
        idle_in(); hiwr = 1; hid = 6'h31;
        step("R4 second write", "R7 quiet");
        idle_in(); swwr = 1; swval = 1;
        step("R4 write counted toward next", "R7 quiet");
        idle_in(); uf = 1;
        step("R3 no repeat copy", "R7 quiet");
        idle_in();
        // R7/R9: rising edge no dead-time, falling edge yes, one cycle
        os = 3'b010;
        step("R9 quiet", "R7 rising ignored");
        os = 3'b000;
        step("R9 quiet", "R7 falling edge");
        step("R9 quiet", "R9 single cycle");

        // Constrained random
        for (int i = 0; i < 4000; i++) begin
            uf    = ($urandom % 8) == 0;
            swwr  = ($urandom % 10) == 0;
            swval = $urandom % 2;
            perwr = ($urandom % 10) == 0;
            peren = $urandom % 2;
            os    = 3'($urandom);
            lowr  = ($urandom % 4) == 0;
            hiwr  = ($urandom % 4) == 0;
            lod   = PW'($urandom);
            hid   = PW'($urandom);
            if (i % 500 == 0) saw = $urandom % 2;
            if (saw) step("R5 saw copy", "R8 saw dt");
            else     step("R3 tri copy", "R7 tri dt");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule